// File: doc/BRIEF.md
# Streaming Frame Receive Checker

This block sits on the receive side of a 64-bit packet stream carrying Ethernet frames and watches its framing. Each beat comes with valid, start and end markers, a 3-bit count of unused byte lanes and a 6-bit error vector. The block accepts beats only while it drives ready high, and it can pull ready low when asked. It follows each frame from its first beat to its last and works out the frame's length in bytes. It reads the error vector on the final beat and sorts the frame into one of five classes.

The block reports each finished frame as a one-cycle summary carrying the byte count and the class. It keeps a saturating counter for each class and reports any beat that has unused lanes before the end of a frame. Frame payload, checksum and addresses pass through without being inspected, so the block carries no data bus.

Top module: `rx_frame_checker`

## Requirements
- R1: A beat is accepted only in a cycle where in_valid and out_ready are both high. out_ready is low whenever hold_in is high, and also for one cycle while a deferred summary is being issued (see R6).
- R2: For a frame accepted over N beats whose last beat has in_empty = E, sum_bytes = 8*N - E. sum_valid is high for exactly the one cycle after the clock edge that accepted the last beat.
- R3: A beat with in_sop and in_eop both high is a complete frame of 8 - in_empty bytes.
- R4: in_error is read only on the accepted beat that carries in_eop. Its value on every other beat has no effect on the class.
- R5: sum_class codes are good = 0, undersized = 1, overflow = 2, other error = 3 and framing = 4. At frame end, error bit 5 gives overflow. Otherwise error bit 2 gives undersized. Otherwise any other set error bit gives other error. Otherwise the frame is good.
- R6: An accepted in_sop beat inside an open frame closes that frame with class 4 and sum_bytes = 8 * (beats accepted so far), and it opens a new frame. If that beat also has in_eop, its own summary follows one cycle later and out_ready is low during that cycle.
- R7: An accepted beat with in_sop low and no frame open is dropped. It produces no summary and adds one to the framing counter.
- R8: An accepted beat with in_eop low and in_empty non-zero raises proto_err for one cycle after its clock edge.
- R9: Each summary adds one to the counter for its class one clock after sum_valid. Counters stop at their maximum value.
- R10: cnt_clear high at a clock edge zeroes all five counters, and it wins over any increment at that edge.
- R11: After reset, sum_valid and proto_err are low, all counters are zero and out_ready equals not hold_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_in | input | 1 | Backpressure request; forces out_ready low |
| in_valid | input | 1 | Beat valid |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | 3 | Unused byte lanes on the last beat |
| in_error | input | 6 | Error vector, read at frame end |
| cnt_clear | input | 1 | Synchronous clear of all counters |
| out_ready | output | 1 | Beat acceptance |
| sum_valid | output | 1 | One-cycle frame summary strobe |
| sum_bytes | output | 16 | Frame length in bytes |
| sum_class | output | 3 | Frame class code |
| proto_err | output | 1 | Unused lanes seen before frame end |
| cnt_good | output | CNT_W | Good frame counter |
| cnt_undersize | output | CNT_W | Undersized frame counter |
| cnt_overflow | output | CNT_W | Overflow frame counter |
| cnt_error | output | CNT_W | Other-error frame counter |
| cnt_framing | output | CNT_W | Framing error counter |

## Verification
The assertions check several properties on every cycle. Backpressure and a pending deferred summary always force ready low. Every summary has a non-zero length and a legal class code. A dropped beat never comes with a summary. The protocol flag follows an accepted non-final beat. Counters never decrease unless cleared, and they read zero after a clear. The bench scenarios are needed for the properties that depend on a whole frame: byte counts over many beats, the priority among error bits, errors on middle beats having no effect, the summary that follows an abort on a single-beat frame, and saturation of the counters. It checks these against a model of the requirements, using random traffic mixed with directed cases.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

   typedef enum logic [2:0] {
      CLS_GOOD    = 3'd0,
      CLS_UNDER   = 3'd1,
      CLS_OVF     = 3'd2,
      CLS_ERR     = 3'd3,
      CLS_FRAMING = 3'd4
   } frame_class_e;

   localparam int NUM_CLASSES = 5;

endpackage

// File: rtl/rxfc_classifier.sv
module rxfc_classifier
   import rxfc_pkg::*;
#(
   parameter int ERR_W     = 6,
   parameter int UNDER_BIT = 2,
   parameter int OVF_BIT   = 5
) (
   input  logic [ERR_W-1:0] err_vec,
   output frame_class_e     cls
);

   localparam logic [ERR_W-1:0] KNOWN_MASK =
      (ERR_W'(1) << UNDER_BIT) | (ERR_W'(1) << OVF_BIT);

   generate
      if (UNDER_BIT >= ERR_W || OVF_BIT >= ERR_W || UNDER_BIT == OVF_BIT) begin : g_bad_bits
         $error("rxfc_classifier: error bit positions invalid");
      end
   endgenerate

   always_comb begin
      if (err_vec[OVF_BIT])
         cls = CLS_OVF;
      else if (err_vec[UNDER_BIT])
         cls = CLS_UNDER;
      else if ((err_vec & ~KNOWN_MASK) != '0)
         cls = CLS_ERR;
      else
         cls = CLS_GOOD;
   end

endmodule

// File: rtl/rxfc_sat_counter.sv
module rxfc_sat_counter #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] MAX_VAL = '1;

   generate
      if (W < 2) begin : g_bad_w
         $error("rxfc_sat_counter: width too small");
      end

      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (clr)
               cnt <= '0;
            else if (inc && cnt != MAX_VAL)
               cnt <= cnt + 1'b1;
         end

         // R9: a saturating counter never goes down unless cleared
         a_r9_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> cnt >= $past(cnt));
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (clr)
               cnt <= '0;
            else if (inc)
               cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   // R10: a clear leaves zero behind
   a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);

endmodule

// File: rtl/rxfc_tracker.sv
module rxfc_tracker
   import rxfc_pkg::*;
#(
   parameter int SYMS    = 8,
   parameter int EMPTY_W = 3,
   parameter int LEN_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold_in,
   input  logic               in_valid,
   input  logic               in_sop,
   input  logic               in_eop,
   input  logic [EMPTY_W-1:0] in_empty,
   input  frame_class_e       end_cls,
   output logic               out_ready,
   output logic               sum_valid,
   output logic [LEN_W-1:0]   sum_bytes,
   output frame_class_e       sum_cls,
   output logic               drop_pulse,
   output logic               proto_pulse
);

   localparam int BEAT_W = LEN_W - EMPTY_W;
   localparam logic [BEAT_W-1:0] BEAT_MAX = '1;

   generate
      if ((1 << EMPTY_W) != SYMS) begin : g_bad_syms
         $error("rxfc_tracker: symbol count must equal 2**EMPTY_W");
      end
      if (BEAT_W < 2) begin : g_bad_len
         $error("rxfc_tracker: length width too small");
      end
   endgenerate

   logic               in_frame_q;
   logic [BEAT_W-1:0]  beats_q;
   logic               pend_q;
   logic [LEN_W-1:0]   pend_bytes_q;
   frame_class_e       pend_cls_q;

   logic               acc;
   logic [BEAT_W-1:0]  beats_inc;
   logic [LEN_W-1:0]   bytes_last;
   logic [LEN_W-1:0]   bytes_single;
   logic [LEN_W-1:0]   bytes_abort;

   assign out_ready    = !hold_in && !pend_q;
   assign acc          = in_valid && out_ready;
   assign beats_inc    = (beats_q == BEAT_MAX) ? beats_q : beats_q + 1'b1;
   assign bytes_last   = {beats_inc, {EMPTY_W{1'b0}}} - LEN_W'(in_empty);
   assign bytes_single = LEN_W'(SYMS) - LEN_W'(in_empty);
   assign bytes_abort  = {beats_q, {EMPTY_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q   <= 1'b0;
         beats_q      <= '0;
         pend_q       <= 1'b0;
         pend_bytes_q <= '0;
         pend_cls_q   <= CLS_GOOD;
         sum_valid    <= 1'b0;
         sum_bytes    <= '0;
         sum_cls      <= CLS_GOOD;
         drop_pulse   <= 1'b0;
         proto_pulse  <= 1'b0;
      end else begin
         sum_valid   <= 1'b0;
         drop_pulse  <= 1'b0;
         proto_pulse <= 1'b0;
         if (pend_q) begin
            sum_valid <= 1'b1;
            sum_bytes <= pend_bytes_q;
            sum_cls   <= pend_cls_q;
            pend_q    <= 1'b0;
         end else if (acc) begin
            proto_pulse <= !in_eop && (in_empty != '0);
            if (in_sop) begin
               if (in_frame_q) begin
                  sum_valid <= 1'b1;
                  sum_bytes <= bytes_abort;
                  sum_cls   <= CLS_FRAMING;
                  if (in_eop) begin
                     pend_q       <= 1'b1;
                     pend_bytes_q <= bytes_single;
                     pend_cls_q   <= end_cls;
                     in_frame_q   <= 1'b0;
                  end else begin
                     beats_q <= BEAT_W'(1);
                  end
               end else if (in_eop) begin
                  sum_valid <= 1'b1;
                  sum_bytes <= bytes_single;
                  sum_cls   <= end_cls;
               end else begin
                  in_frame_q <= 1'b1;
                  beats_q    <= BEAT_W'(1);
               end
            end else if (in_frame_q) begin
               if (in_eop) begin
                  sum_valid  <= 1'b1;
                  sum_bytes  <= bytes_last;
                  sum_cls    <= end_cls;
                  in_frame_q <= 1'b0;
               end else begin
                  beats_q <= beats_inc;
               end
            end else begin
               drop_pulse <= 1'b1;
            end
         end
      end
   end

   // R6: a deferred summary blocks the next beat
   a_r6_pend_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !out_ready);
   // R6: the deferred summary is issued on the very next cycle
   a_r6_pend_issues: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> sum_valid);
   // R2: every reported frame has a length
   a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      sum_valid |-> sum_bytes != '0);
   // R5: class code within the defined set
   a_r5_cls_legal: assert property (@(posedge clk) disable iff (!rst_n)
      sum_valid |-> sum_cls <= CLS_FRAMING);
   // R7: a dropped beat yields no summary
   a_r7_drop_no_sum: assert property (@(posedge clk) disable iff (!rst_n)
      drop_pulse |-> !sum_valid);
   // R8: protocol flag only after an accepted beat without end marker
   a_r8_proto_src: assert property (@(posedge clk) disable iff (!rst_n)
      proto_pulse |-> $past(in_valid && out_ready && !in_eop));

endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
   import rxfc_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int LEN_W     = 16,
   parameter int CNT_W     = 32,
   parameter int ERR_W     = 6,
   parameter int UNDER_BIT = 2,
   parameter int OVF_BIT   = 5,
   parameter bit SATURATE  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          hold_in,
   input  logic                          in_valid,
   input  logic                          in_sop,
   input  logic                          in_eop,
   input  logic [$clog2(DATA_W/8)-1:0]   in_empty,
   input  logic [ERR_W-1:0]              in_error,
   input  logic                          cnt_clear,
   output logic                          out_ready,
   output logic                          sum_valid,
   output logic [LEN_W-1:0]              sum_bytes,
   output logic [2:0]                    sum_class,
   output logic                          proto_err,
   output logic [CNT_W-1:0]              cnt_good,
   output logic [CNT_W-1:0]              cnt_undersize,
   output logic [CNT_W-1:0]              cnt_overflow,
   output logic [CNT_W-1:0]              cnt_error,
   output logic [CNT_W-1:0]              cnt_framing
);

   localparam int SYMS    = DATA_W / 8;
   localparam int EMPTY_W = $clog2(SYMS);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
         $error("rx_frame_checker: data width must be a multiple of 8 and at least 16");
      end
   endgenerate

   frame_class_e end_cls;
   frame_class_e sum_cls;
   logic         drop_pulse;
   logic [NUM_CLASSES-1:0] inc;
   logic [CNT_W-1:0]       cnt_arr [NUM_CLASSES];

   rxfc_classifier #(
      .ERR_W     (ERR_W),
      .UNDER_BIT (UNDER_BIT),
      .OVF_BIT   (OVF_BIT)
   ) u_cls (
      .err_vec (in_error),
      .cls     (end_cls)
   );

   rxfc_tracker #(
      .SYMS    (SYMS),
      .EMPTY_W (EMPTY_W),
      .LEN_W   (LEN_W)
   ) u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_in     (hold_in),
      .in_valid    (in_valid),
      .in_sop      (in_sop),
      .in_eop      (in_eop),
      .in_empty    (in_empty),
      .end_cls     (end_cls),
      .out_ready   (out_ready),
      .sum_valid   (sum_valid),
      .sum_bytes   (sum_bytes),
      .sum_cls     (sum_cls),
      .drop_pulse  (drop_pulse),
      .proto_pulse (proto_err)
   );

   assign sum_class = sum_cls;

   generate
      for (genvar gi = 0; gi < NUM_CLASSES; gi++) begin : g_cnt
         if (gi == int'(CLS_FRAMING)) begin : g_frm
            assign inc[gi] = (sum_valid && sum_cls == frame_class_e'(gi)) || drop_pulse;
         end else begin : g_cls
            assign inc[gi] = sum_valid && sum_cls == frame_class_e'(gi);
         end
         rxfc_sat_counter #(
            .W        (CNT_W),
            .SATURATE (SATURATE)
         ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clear),
            .inc   (inc[gi]),
            .cnt   (cnt_arr[gi])
         );
      end
   endgenerate

   assign cnt_good      = cnt_arr[CLS_GOOD];
   assign cnt_undersize = cnt_arr[CLS_UNDER];
   assign cnt_overflow  = cnt_arr[CLS_OVF];
   assign cnt_error     = cnt_arr[CLS_ERR];
   assign cnt_framing   = cnt_arr[CLS_FRAMING];

   // R1: backpressure request always lowers ready
   a_r1_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
      hold_in |-> !out_ready);
   // R9: at most one class counts per summary
   a_r9_one_inc: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(inc));

endmodule

// File: tb/test_rx_frame_checker.sv
`timescale 1ns/1ps
module test_rx_frame_checker;

   localparam int CW = 5;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_in = 1'b0, in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, cnt_clear = 1'b0;
   logic [2:0] in_empty = '0;
   logic [5:0] in_error = '0;
   logic out_ready, sum_valid, proto_err;
   logic [15:0] sum_bytes;
   logic [2:0] sum_class;
   logic [CW-1:0] c_good, c_under, c_ovf, c_err, c_frm;

   always #4 clk = ~clk;

   rx_frame_checker #(.CNT_W(CW)) i_rx_frame_checker (
      .clk(clk), .rst_n(rst_n), .hold_in(hold_in), .in_valid(in_valid),
      .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_error(in_error),
      .cnt_clear(cnt_clear), .out_ready(out_ready), .sum_valid(sum_valid),
      .sum_bytes(sum_bytes), .sum_class(sum_class), .proto_err(proto_err),
      .cnt_good(c_good), .cnt_undersize(c_under), .cnt_overflow(c_ovf),
      .cnt_error(c_err), .cnt_framing(c_frm));

   int checks = 0, failures = 0;
   bit done = 0;

   // model state
   bit m_in = 0, m_pend = 0;
   int m_beats = 0, m_pbytes = 0, m_pcls = 0;
   int m_cnt [5] = '{0, 0, 0, 0, 0};
   bit inc_prev [5] = '{0, 0, 0, 0, 0};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // R5: classification from the error vector at frame end
   function automatic int cls_of(input logic [5:0] e);
      if (e[5]) return 2;
      if (e[2]) return 1;
      if ((e & 6'b011011) != 0) return 3;
      return 0;
   endfunction

   task automatic step(input bit v, s, e, input logic [2:0] em, input logic [5:0] er,
                       input bit hold, clr);
      bit rdy, acc, sv, prot, drop;
      int bytes, cls;
      sv = 0; prot = 0; drop = 0; bytes = 0; cls = 0;
      in_valid = v; in_sop = s; in_eop = e; in_empty = em; in_error = er;
      hold_in = hold; cnt_clear = clr;
      rdy = !hold && !m_pend;
      #1;
      chk("R1 ready", out_ready, rdy);
      acc = v && rdy;
      if (m_pend) begin
         sv = 1; bytes = m_pbytes; cls = m_pcls; m_pend = 0;
      end else if (acc) begin
         prot = !e && em != 0;
         if (s) begin
            if (m_in) begin
               sv = 1; bytes = m_beats * 8; cls = 4;
               if (e) begin
                  m_pend = 1; m_pbytes = 8 - em; m_pcls = cls_of(er); m_in = 0;
               end else m_beats = 1;
            end else if (e) begin
               sv = 1; bytes = 8 - em; cls = cls_of(er);
            end else begin
               m_in = 1; m_beats = 1;
            end
         end else if (m_in) begin
            m_beats++;
            if (e) begin
               sv = 1; bytes = m_beats * 8 - em; cls = cls_of(er); m_in = 0;
            end
         end else drop = 1;
      end
      @(negedge clk);
      chk("R2 sum_valid", sum_valid, sv);
      if (sv) begin
         chk("R2 sum_bytes", sum_bytes, bytes);
         chk("R5 sum_class", sum_class, cls);
      end
      chk("R8 proto_err", proto_err, prot);
      for (int i = 0; i < 5; i++) begin
         if (clr) m_cnt[i] = 0;
         else if (inc_prev[i] && m_cnt[i] < CMAX) m_cnt[i]++;
      end
      chk("R9 cnt_good", c_good, m_cnt[0]);
      chk("R9 cnt_undersize", c_under, m_cnt[1]);
      chk("R9 cnt_overflow", c_ovf, m_cnt[2]);
      chk("R9 cnt_error", c_err, m_cnt[3]);
      chk("R7 cnt_framing", c_frm, m_cnt[4]);
      for (int i = 0; i < 5; i++) inc_prev[i] = (sv && cls == i) || (drop && i == 4);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1207));
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 ready", out_ready, 1);
      chk("R11 sum_valid", sum_valid, 0);
      chk("R11 proto_err", proto_err, 0);
      chk("R11 cnt_good", c_good, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: three beats, empty 3 -> 21 bytes, good
      step(1, 1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 6'h3f, 0, 0);   // R4: middle-beat errors ignored
      step(1, 0, 1, 3, 0, 0, 0);
      idle(2);
      // R5: undersize, overflow over undersize, other error
      step(1, 1, 0, 0, 0, 0, 0); step(1, 0, 1, 0, 6'b000100, 0, 0);
      step(1, 1, 0, 0, 0, 0, 0); step(1, 0, 1, 1, 6'b100100, 0, 0);
      step(1, 1, 0, 0, 0, 0, 0); step(1, 0, 1, 2, 6'b000001, 0, 0);
      idle(2);
      // R3: single-beat frame, empty 7 -> 1 byte
      step(1, 1, 1, 7, 0, 0, 0);
      // R1: hold blocks beats
      step(1, 1, 0, 0, 0, 1, 0);
      step(1, 1, 0, 0, 0, 0, 0);
      // R6: abort by new sop, then abort with sop+eop (deferred summary)
      step(1, 0, 0, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0, 0);
      step(1, 1, 1, 4, 6'b000100, 0, 0);
      step(1, 1, 1, 0, 0, 0, 0);       // blocked by pending summary
      idle(2);
      // R7: stray beat dropped
      step(1, 0, 0, 0, 0, 0, 0);
      step(1, 0, 1, 0, 0, 0, 0);
      // R8: empty on a non-final beat
      step(1, 1, 0, 5, 0, 0, 0);
      step(1, 0, 1, 0, 0, 0, 0);
      idle(2);
      // R10: clear with a pending increment
      step(1, 1, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1);
      idle(2);
      // R9: saturation of the good counter
      for (int i = 0; i < CMAX + 6; i++) step(1, 1, 1, 0, 0, 0, 0);
      idle(3);
      step(0, 0, 0, 0, 0, 0, 1);
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         bit v, s, e, h, c;
         logic [2:0] em;
         logic [5:0] er;
         v = ($urandom_range(0, 9) < 8);
         s = ($urandom_range(0, 4) == 0);
         e = ($urandom_range(0, 3) == 0);
         h = ($urandom_range(0, 7) == 0);
         c = ($urandom_range(0, 199) == 0);
         em = ($urandom_range(0, 5) == 0 || e) ? 3'($urandom_range(0, 7)) : 3'd0;
         er = ($urandom_range(0, 2) == 0) ? 6'($urandom_range(0, 63)) : 6'd0;
         step(v, s, e, em, er, h, c);
      end
      idle(3);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule